// File: doc/BRIEF.md
# Power Mode and Wake-up Controller

This block decides when the clocks of a small 8-bit microcontroller run. Software writes a control byte that asks for a light sleep or a deep sleep and selects how a deep-sleep wake-up is released. In light sleep (idle) only the CPU clock stops. The peripheral clock keeps running, and the comparator and watchdog clocks each follow their own enable bit. Any enabled pending interrupt, or the external reset pin, brings the CPU back. In deep sleep (power-down) the oscillator enable drops, and every clock stops with it.

Only a falling edge on one of the two active-low external interrupt pins can wake the part from power-down, and only if that pin is enabled and configured level-sensitive. The external reset pin can also wake it. After an interrupt wake the CPU clock is released in one of two ways. In the timed mode it is released after a start-up count of `STARTUP_CYC` cycles. In the pin-released mode it is released when the waking pin returns high. A reset wake runs the same start-up count and then waits for the reset pin to fall. After any reset and after any power-down exit, a new power-down request is refused for `LOCK_CYC` cycles.

The block runs from an always-on counting clock. It synchronises its pins with two flops each and keeps its sequencing in one state machine. The states are RUN, IDLE, PDOWN, WARM (start-up count), PINHOLD (waiting for the pin to rise), RSTHOLD (waiting for the reset pin to fall after the count) and RESET (reset pin held while awake). The transitions are:

- RUN→IDLE on an idle request.
- RUN→PDOWN on an unlocked power-down request.
- RUN→RESET and IDLE→RESET when the reset pin is high.
- IDLE→RUN on a pending interrupt.
- PDOWN→WARM on a reset or a timed-mode pin wake.
- PDOWN→PINHOLD on a pin-released wake.
- WARM→RUN when the count ends after a pin wake.
- WARM→RSTHOLD when the count ends after a reset wake.
- PINHOLD→RUN when the pin rises.
- RSTHOLD→RUN and RESET→RUN when the reset pin falls.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: When the power-on reset is released, every clock enable output is 1 and `wake_irq` is 0.
- R2: A control write with bit 0 (idle) set in RUN gates `cpu_clk_en` from the next cycle. `osc_en` and `periph_clk_en` stay 1 while idle.
- R3: While idle, `cmp_clk_en` equals bit 3 and `wdt_clk_en` equals bit 4 of the write that entered idle.
- R4: While idle, any set bit of `irq_pend` restores `cpu_clk_en` on the next cycle, and `wake_irq` is 1 for exactly that one cycle.
- R5: The reset pin ends idle 3 cycles after it rises (two-flop synchroniser plus the state register). This leaves `cpu_clk_en` at 1 and `wake_irq` at 0.
- R6: A write with bit 1 (power-down) set, when not locked, drops `osc_en`, `cpu_clk_en` and `periph_clk_en` on the next cycle. When bits 0 and 1 are both set, power-down wins.
- R7: In power-down, only a falling edge on an interrupt pin that has its enable bit at 1 and its edge-select bit at 0 wakes the block, with `osc_en` rising 3 cycles after the pin falls. A disabled or edge-configured pin leaves `osc_en` at 0. When both pins fall together, pin 0 is the waking pin.
- R8: With bit 2 of the power-down write at 0, a pin wake keeps `cpu_clk_en` at 0 for exactly `STARTUP_CYC` cycles after `osc_en` rises, whatever the pin does. It then sets `cpu_clk_en` together with a one-cycle `wake_irq`.
- R9: With bit 2 at 1, `cpu_clk_en` stays 0 while the waking pin is low. It is released with `wake_irq` 3 cycles after that pin rises.
- R10: The reset pin wakes power-down and raises `osc_en` after 3 cycles. `cpu_clk_en` stays 0 until `STARTUP_CYC` cycles have passed and the pin has fallen again. It is released 3 cycles after the fall, with no `wake_irq`.
- R11: A power-down request is ignored while fewer than `LOCK_CYC` cycles have passed since RUN was entered after a reset or a power-down exit, or since the power-on reset. The idle bit in the same write still takes effect.
- R12: The idle and power-down requests do not persist. After an exit, the CPU clock keeps running until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on counting clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control byte: 0 idle, 1 power-down, 2 pin-released wake, 3 comparator idle clock, 4 watchdog idle clock |
| xint_n | input | NXINT | External interrupt pins, active low |
| xint_en | input | NXINT | Per-pin interrupt enable |
| xint_edge | input | NXINT | Per-pin trigger select, 1 edge, 0 level |
| rst_pin | input | 1 | External reset pin, active high |
| irq_pend | input | NIRQ | Enabled pending interrupt flags |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Timer, serial and SPI clock gate enable |
| cmp_clk_en | output | 1 | Comparator clock gate enable |
| wdt_clk_en | output | 1 | Watchdog clock gate enable |
| wake_irq | output | 1 | One-cycle request to service the waking interrupt |

## Verification
A power-down request can reach the state machine in the same cycle that the re-entry lockout runs out. The bench leaves power-down through the reset pin and then issues the request at every offset from 0 to `LOCK_CYC` cycles after RUN is re-entered. The expected result is computed as "refused below `LOCK_CYC`, accepted at it". Idle and power-down requests are also made to arrive in one write, both while locked and while unlocked. The bench checks that power-down wins when allowed and that idle takes effect when it is refused.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    localparam int CTL_W    = 5;
    localparam int CB_IDLE  = 0;
    localparam int CB_PDOWN = 1;
    localparam int CB_XREL  = 2;
    localparam int CB_CMP   = 3;
    localparam int CB_WDT   = 4;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_WARM,
        ST_PINHOLD,
        ST_RSTHOLD,
        ST_RESET
    } pm_state_e;

    typedef enum logic {
        SRC_XINT,
        SRC_RSTPIN
    } wake_src_e;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pwr_startup_cnt.sv
module pwr_startup_cnt #(
    parameter int CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwr_lockout.sv
module pwr_lockout #(
    parameter int CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic locked
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    assign locked = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= CW'(CYC);
        else if (reload)   cnt <= CW'(CYC);
        else if (locked)   cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int NXINT       = 2,
    parameter int NIRQ        = 4,
    parameter int STARTUP_CYC = 40000,
    parameter int LOCK_CYC    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [NXINT-1:0] xint_n,
    input  logic [NXINT-1:0] xint_en,
    input  logic [NXINT-1:0] xint_edge,
    input  logic             rst_pin,
    input  logic [NIRQ-1:0]  irq_pend,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             cmp_clk_en,
    output logic             wdt_clk_en,
    output logic             wake_irq
);
    localparam int IW = (NXINT > 1) ? $clog2(NXINT) : 1;

    // synchronised pins
    logic [NXINT-1:0] xint_s;
    logic [NXINT-1:0] xint_d;
    logic             rst_s;

    pwr_sync #(.W(NXINT), .RST_VAL({NXINT{1'b1}})) u_xsync (
        .clk(clk), .rst_n(rst_n), .d(xint_n), .q(xint_s)
    );

    pwr_sync #(.W(1), .RST_VAL(1'b0)) u_rsync (
        .clk(clk), .rst_n(rst_n), .d(rst_pin), .q(rst_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xint_d <= '1;
        else        xint_d <= xint_s;
    end

    // per-pin qualified falling edge
    logic [NXINT-1:0] qual;
    genvar g;
    generate
        for (g = 0; g < NXINT; g++) begin : g_pin
            assign qual[g] = xint_d[g] & ~xint_s[g] & xint_en[g] & ~xint_edge[g];
        end
    endgenerate

    logic [IW-1:0] pick;
    always_comb begin
        pick = '0;
        for (int i = NXINT - 1; i >= 0; i--) begin
            if (qual[i]) pick = IW'(i);
        end
    end

    // state and configuration
    pm_state_e  state_q, state_d;
    wake_src_e  src_q, src_d;
    logic [IW-1:0] idx_q, idx_d;
    logic       wake_q, wake_d;
    logic       relock;
    logic       cfg_xrel, cfg_cmp, cfg_wdt;
    logic       idle_req, pd_req;
    logic       locked;
    logic       start_done;

    assign idle_req = ctl_we && ctl_wdata[CB_IDLE];
    assign pd_req   = ctl_we && ctl_wdata[CB_PDOWN];

    pwr_startup_cnt #(.CYC(STARTUP_CYC)) u_start (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_WARM), .done(start_done)
    );

    pwr_lockout #(.CYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .reload(relock), .locked(locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_xrel <= 1'b0;
            cfg_cmp  <= 1'b1;
            cfg_wdt  <= 1'b1;
        end else if (ctl_we && state_q == ST_RUN) begin
            cfg_xrel <= ctl_wdata[CB_XREL];
            cfg_cmp  <= ctl_wdata[CB_CMP];
            cfg_wdt  <= ctl_wdata[CB_WDT];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= SRC_XINT;
            idx_q   <= '0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            idx_q   <= idx_d;
            wake_q  <= wake_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        idx_d   = idx_q;
        wake_d  = 1'b0;
        relock  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (rst_s)                    state_d = ST_RESET;
                else if (pd_req && !locked)   state_d = ST_PDOWN;
                else if (idle_req)            state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_s) begin
                    state_d = ST_RESET;
                end else if (|irq_pend) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            ST_PDOWN: begin
                if (rst_s) begin
                    state_d = ST_WARM;
                    src_d   = SRC_RSTPIN;
                end else if (|qual) begin
                    idx_d = pick;
                    if (cfg_xrel) begin
                        state_d = ST_PINHOLD;
                    end else begin
                        state_d = ST_WARM;
                        src_d   = SRC_XINT;
                    end
                end
            end
            ST_WARM: begin
                if (start_done) begin
                    if (src_q == SRC_XINT) begin
                        state_d = ST_RUN;
                        wake_d  = 1'b1;
                        relock  = 1'b1;
                    end else begin
                        state_d = ST_RSTHOLD;
                    end
                end
            end
            ST_PINHOLD: begin
                if (xint_s[idx_q]) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                    relock  = 1'b1;
                end
            end
            ST_RSTHOLD, ST_RESET: begin
                if (!rst_s) begin
                    state_d = ST_RUN;
                    relock  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        osc_en        = 1'b1;
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        cmp_clk_en    = 1'b0;
        wdt_clk_en    = 1'b0;
        unique case (state_q)
            ST_RUN, ST_RESET: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
                cmp_clk_en    = 1'b1;
                wdt_clk_en    = 1'b1;
            end
            ST_IDLE: begin
                periph_clk_en = 1'b1;
                cmp_clk_en    = cfg_cmp;
                wdt_clk_en    = cfg_wdt;
            end
            ST_PDOWN: osc_en = 1'b0;
            ST_WARM, ST_PINHOLD, ST_RSTHOLD: ;
            default: ;
        endcase
    end

    assign wake_irq = wake_q;

endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
    import pwr_wake_pkg::*;
#(
    parameter int NXINT = 2,
    parameter int IW    = 1
) (
    input logic             clk,
    input logic             rst_n,
    input pm_state_e        state,
    input logic             rst_s,
    input logic             idle_req,
    input logic             pd_req,
    input logic             locked,
    input logic [NXINT-1:0] xint_s,
    input logic [IW-1:0]    idx,
    input logic             osc_en,
    input logic             cpu_clk_en,
    input logic             periph_clk_en,
    input logic             wake_irq
);
    AST_IDLE_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !rst_s && idle_req && !pd_req) |=> !cpu_clk_en); // R2

    AST_WAKE_WITH_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> cpu_clk_en); // R4

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq); // R4

    AST_NO_CLOCK_WITHOUT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en)); // R6

    AST_OSC_RESTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !cpu_clk_en); // R8

    AST_PINHOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PINHOLD && !xint_s[idx]) |=> !cpu_clk_en); // R9

    AST_RSTHOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSTHOLD && rst_s) |=> !cpu_clk_en); // R10

    AST_LOCKED_PD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !rst_s && pd_req && locked) |=> osc_en); // R11
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.NXINT(NXINT), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .rst_s(rst_s),
    .idle_req(idle_req), .pd_req(pd_req), .locked(locked),
    .xint_s(xint_s), .idx(idx_q), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .wake_irq(wake_irq)
);

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
    localparam int CLK_P   = 10;
    localparam int STARTUP = 6;
    localparam int LOCK    = 4;
    localparam int NIRQ    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [1:0] xint_n = 2'b11;
    logic [1:0] xint_en = 2'b00;
    logic [1:0] xint_edge = 2'b00;
    logic       rst_pin = 1'b0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic osc_en, cpu_clk_en, periph_clk_en, cmp_clk_en, wdt_clk_en, wake_irq;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_P / 2) clk = ~clk;

    pwr_wake_ctrl #(.NXINT(2), .NIRQ(NIRQ), .STARTUP_CYC(STARTUP), .LOCK_CYC(LOCK)) i_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .xint_n(xint_n), .xint_en(xint_en), .xint_edge(xint_edge), .rst_pin(rst_pin),
        .irq_pend(irq_pend), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .cmp_clk_en(cmp_clk_en),
        .wdt_clk_en(wdt_clk_en), .wake_irq(wake_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [4:0] v);
        ctl_wdata = v;
        ctl_we    = 1'b1;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    // leave power-down through the reset pin; ends in the first RUN cycle
    task automatic recover_by_reset();
        rst_pin = 1'b1;
        tick(3);
        chk("R10 osc on after reset pin", osc_en, 1);
        chk("R10 cpu gated at start", cpu_clk_en, 0);
        tick(STARTUP + 2);
        chk("R10 cpu gated while pin high", cpu_clk_en, 0);
        rst_pin = 1'b0;
        tick(2);
        chk("R10 cpu gated until pin synced", cpu_clk_en, 0);
        tick(1);
        chk("R10 cpu released", cpu_clk_en, 1);
        chk("R10 no wake_irq", wake_irq, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 periph_clk_en", periph_clk_en, 1);
        chk("R1 cmp/wdt", {cmp_clk_en, wdt_clk_en}, 3);
        chk("R1 wake_irq", wake_irq, 0);

        // power-on lockout
        write_ctl(5'b00010);
        chk("R11 pd refused after power-on", osc_en, 1);
        tick(LOCK + 2);

        // idle sweep over comparator/watchdog bits and interrupt lines
        for (int c = 0; c < 4; c++) begin
            write_ctl({c[1], c[0], 3'b001});
            chk("R2 cpu gated in idle", cpu_clk_en, 0);
            chk("R2 periph on in idle", periph_clk_en, 1);
            chk("R2 osc on in idle", osc_en, 1);
            chk("R3 cmp clock", cmp_clk_en, c & 1);
            chk("R3 wdt clock", wdt_clk_en, (c >> 1) & 1);
            tick(2);
            chk("R4 stays idle without irq", cpu_clk_en, 0);
            irq_pend = NIRQ'(1 << c);
            tick(1);
            irq_pend = '0;
            chk("R4 cpu back", cpu_clk_en, 1);
            chk("R4 wake_irq set", wake_irq, 1);
            tick(1);
            chk("R4 wake_irq one cycle", wake_irq, 0);
            tick(3);
            chk("R12 idle not re-entered", cpu_clk_en, 1);
        end

        // reset pin ends idle
        write_ctl(5'b11001);
        rst_pin = 1'b1;
        tick(2);
        chk("R5 still idle before sync", cpu_clk_en, 0);
        tick(1);
        chk("R5 cpu on by reset", cpu_clk_en, 1);
        chk("R5 no wake_irq", wake_irq, 0);
        rst_pin = 1'b0;
        tick(LOCK + 4);

        // idle and power-down in one write: power-down wins
        write_ctl(5'b00011);
        chk("R6 osc off", osc_en, 0);
        chk("R6 cpu off", cpu_clk_en, 0);
        chk("R6 periph off", periph_clk_en, 0);
        recover_by_reset();
        tick(LOCK + 2);

        // power-down wake sweep: pin x enable x trigger x release mode
        for (int t = 0; t < 16; t++) begin
            int  pin  = t & 1;
            int  en   = (t >> 1) & 1;
            int  edg  = (t >> 2) & 1;
            int  xrel = (t >> 3) & 1;
            int  qual = en & (1 - edg);
            xint_en   = 2'(en << pin);
            xint_edge = edg ? 2'b11 : 2'b00;
            write_ctl({2'b00, xrel[0], 2'b10});
            chk("R6 enter power-down", osc_en, 0);
            xint_n[pin] = 1'b0;
            if (qual == 0) begin
                tick(6);
                chk("R7 unqualified pin ignored", osc_en, 0);
                xint_n[pin] = 1'b1;
                tick(2);
                recover_by_reset();
            end else if (xrel == 0) begin
                tick(3);
                chk("R7 osc on after pin fall", osc_en, 1);
                chk("R8 cpu gated", cpu_clk_en, 0);
                if (pin == 0) xint_n[pin] = 1'b1;
                tick(STARTUP - 1);
                chk("R8 cpu gated at last count", cpu_clk_en, 0);
                tick(1);
                chk("R8 cpu released", cpu_clk_en, 1);
                chk("R8 wake_irq", wake_irq, 1);
                tick(1);
                chk("R8 wake_irq one cycle", wake_irq, 0);
                xint_n[pin] = 1'b1;
            end else begin
                tick(3);
                chk("R7 osc on after pin fall", osc_en, 1);
                tick(STARTUP + 3);
                chk("R9 cpu gated while pin low", cpu_clk_en, 0);
                xint_n[pin] = 1'b1;
                tick(2);
                chk("R9 cpu gated until pin synced", cpu_clk_en, 0);
                tick(1);
                chk("R9 cpu released", cpu_clk_en, 1);
                chk("R9 wake_irq", wake_irq, 1);
            end
            tick(LOCK + 2);
        end

        // both pins fall together: pin 0 is the one that must rise
        xint_en = 2'b11;
        xint_edge = 2'b00;
        write_ctl(5'b00110);
        xint_n = 2'b00;
        tick(4);
        xint_n[1] = 1'b1;
        tick(4);
        chk("R7 pin 0 has priority", cpu_clk_en, 0);
        xint_n[0] = 1'b1;
        tick(3);
        chk("R7 released by pin 0", cpu_clk_en, 1);
        tick(LOCK + 2);

        // lockout sweep after a power-down exit
        for (int k = 0; k <= LOCK; k++) begin
            write_ctl(5'b00010);
            recover_by_reset();
            tick(k);
            write_ctl(5'b00010);
            chk("R11 lockout boundary", osc_en, (k >= LOCK) ? 0 : 1);
            if (k >= LOCK) recover_by_reset();
            tick(LOCK + 2);
        end

        // locked power-down with idle in the same write: idle is taken
        write_ctl(5'b00010);
        recover_by_reset();
        write_ctl(5'b00011);
        chk("R11 idle taken while pd locked", cpu_clk_en, 0);
        chk("R11 osc stays on", osc_en, 1);
        irq_pend = 4'b0001;
        tick(1);
        irq_pend = '0;
        chk("R11 idle exit", cpu_clk_en, 1);
        tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule